// File: doc/BRIEF.md
# Round-Robin Collision Serialiser

This block sits behind a parallel bounding-box overlap tester. In any clock cycle the tester may report up to `LANES` overlapping pairs at once, one per lane, each pair being two box indices. The serialiser stores every reported pair and turns the parallel reports into a single stream of pairs, one per accepted output handshake, suitable for writing one after another into host-visible memory.

Each lane stores its two indices in two separate index FIFOs that are always written and read together. A round-robin scheduler chooses which lane feeds the registered output stage. When any lane is close to full, the block raises a stall towards the tester so that no report is ever lost. A running total of emitted pairs is kept for the current detection pass. A done flag tells the host that the pass has ended and every stored pair has left the block.

Top module: `collide_serialiser`

## Requirements
- R1: When `hit_valid[k]` is high on a clock edge, the pair (`hit_a` slice k, `hit_b` slice k) is stored in lane k. It later appears on `out_a`/`out_b` as the same pair; the two indices are never separated.
- R2: Pairs that entered the same lane are emitted in the order they arrived, and every stored pair is emitted exactly once.
- R3: The output register reloads whenever it is empty or `out_ready` is high. It takes from the first non-empty lane, searching upward and wrapping, starting one past the lane granted last (lane 0 after reset). Empty lanes are skipped in the same cycle. A pair stored on an edge can be chosen from the next edge on.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_a` and `out_b` hold their values.
- R5: `hit_stall` is high exactly when some lane holds at least `DEPTH-1` pairs. As long as the source sends no report while `hit_stall` is high, no report is ever dropped.
- R6: `hit_count` rises by one on each edge with `out_valid && out_ready`. A `pass_start` pulse clears it to zero, and that clear takes priority over a handshake on the same edge.
- R7: `pass_done` rises one edge after these three things are all true together: `pass_end` has been seen since the last `pass_start`, all lanes are empty, and `out_valid` is low. `pass_start` clears it.
- R8: After reset, `out_valid`, `hit_stall`, `pass_done` and `hit_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pass_start | input | 1 | Pulse: start of a detection pass; clears count, end flag and done |
| pass_end | input | 1 | Pulse: the tester has sent its last report of the pass |
| hit_valid | input | LANES | One valid bit per lane |
| hit_a | input | LANES*IDX_W | First box index of each lane, lane k at bits k*IDX_W upward |
| hit_b | input | LANES*IDX_W | Second box index of each lane |
| hit_stall | output | 1 | Source must not send reports while high |
| out_valid | output | 1 | Output pair is valid |
| out_ready | input | 1 | Sink accepts the output pair |
| out_a | output | IDX_W | First index of the emitted pair |
| out_b | output | IDX_W | Second index of the emitted pair |
| pass_done | output | 1 | Pass ended and all stored pairs have been emitted |
| hit_count | output | CNT_W | Number of pairs emitted in the current pass |

## Verification
The assertions assume that the source keeps `hit_valid` at zero while `hit_stall` is high. They also assume that it sends no reports between `pass_end` and the next `pass_start`. The stimulus samples `hit_stall` away from the clock edge and blanks the valid bits while it is high. Its dense phase still drives occupancy up to the threshold, so that the stall path is exercised. The sink's ready signal is randomised so that the output is often held with data waiting. Sparse phases load only one or two lanes, so that the scheduler has to skip across empty lanes and wrap past the top lane.

// File: rtl/collide_pkg.sv
package collide_pkg;
  // Circular step used by the scheduler and its pointer.
  function automatic int wrap_add(input int base, input int step, input int modulus);
    return (base + step) % modulus;
  endfunction
endpackage

// File: rtl/idx_fifo.sv
module idx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         afull
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt, cnt_n;
  logic          push_ok, pop_ok, afull_q;

  assign push_ok = push && (cnt != (AW+1)'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);
  assign cnt_n   = cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      afull_q <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt     <= cnt_n;
      afull_q <= (cnt_n >= (AW+1)'(DEPTH-1));
    end
  end

  assign dout  = mem[rptr];
  assign empty = (cnt == '0);
  assign afull = afull_q;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N     = 7,
  parameter int SEL_W = 3
) (
  input  logic [N-1:0]     req,
  input  logic [SEL_W-1:0] ptr,
  output logic [N-1:0]     grant,
  output logic [SEL_W-1:0] gidx,
  output logic             any
);
  import collide_pkg::*;

  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[wrap_add(int'(ptr), k, N)]) begin
        any   = 1'b1;
        grant[wrap_add(int'(ptr), k, N)] = 1'b1;
        gidx  = SEL_W'(wrap_add(int'(ptr), k, N));
      end
    end
  end
endmodule

// File: rtl/collide_serialiser.sv
module collide_serialiser #(
  parameter int LANES = 7,
  parameter int IDX_W = 9,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pass_start,
  input  logic                   pass_end,
  input  logic [LANES-1:0]       hit_valid,
  input  logic [LANES*IDX_W-1:0] hit_a,
  input  logic [LANES*IDX_W-1:0] hit_b,
  output logic                   hit_stall,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [IDX_W-1:0]       out_a,
  output logic [IDX_W-1:0]       out_b,
  output logic                   pass_done,
  output logic [CNT_W-1:0]       hit_count
);
  import collide_pkg::*;

  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDX_W-1:0] rd_a [LANES];
  logic [IDX_W-1:0] rd_b [LANES];
  logic [LANES-1:0] emp_a, emp_b, af_a, af_b;
  logic [LANES-1:0] lane_empty, lane_pop, arb_grant;
  logic [SEL_W-1:0] rr_ptr, arb_idx;
  logic             arb_any, load;

  logic             out_valid_q, end_seen_q, done_q;
  logic [IDX_W-1:0] out_a_q, out_b_q;
  logic [CNT_W-1:0] count_q;

  // One pair of index FIFOs per lane, moved in lock step.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    idx_fifo #(.W(IDX_W), .DEPTH(DEPTH)) u_fifo_a (
      .clk   (clk),
      .rst   (rst),
      .push  (hit_valid[g]),
      .din   (hit_a[g*IDX_W +: IDX_W]),
      .pop   (lane_pop[g]),
      .dout  (rd_a[g]),
      .empty (emp_a[g]),
      .afull (af_a[g])
    );
    idx_fifo #(.W(IDX_W), .DEPTH(DEPTH)) u_fifo_b (
      .clk   (clk),
      .rst   (rst),
      .push  (hit_valid[g]),
      .din   (hit_b[g*IDX_W +: IDX_W]),
      .pop   (lane_pop[g]),
      .dout  (rd_b[g]),
      .empty (emp_b[g]),
      .afull (af_b[g])
    );
  end

  assign lane_empty = emp_a | emp_b;

  rr_pick #(.N(LANES), .SEL_W(SEL_W)) u_sched (
    .req   (~lane_empty),
    .ptr   (rr_ptr),
    .grant (arb_grant),
    .gidx  (arb_idx),
    .any   (arb_any)
  );

  assign load     = !out_valid_q || out_ready;
  assign lane_pop = load ? arb_grant : '0;

  // Registered output stage and scheduler pointer.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_a_q     <= '0;
      out_b_q     <= '0;
      rr_ptr      <= '0;
    end else if (load) begin
      out_valid_q <= arb_any;
      if (arb_any) begin
        out_a_q <= rd_a[arb_idx];
        out_b_q <= rd_b[arb_idx];
        rr_ptr  <= SEL_W'(wrap_add(int'(arb_idx), 1, LANES));
      end
    end
  end

  // Pass bookkeeping: emitted total, end marker, completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q    <= '0;
      end_seen_q <= 1'b0;
      done_q     <= 1'b0;
    end else if (pass_start) begin
      count_q    <= '0;
      end_seen_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (out_valid_q && out_ready) count_q <= count_q + 1'b1;
      if (pass_end) end_seen_q <= 1'b1;
      done_q <= end_seen_q && (&lane_empty) && !out_valid_q;
    end
  end

  assign hit_stall = |(af_a | af_b);
  assign out_valid = out_valid_q;
  assign out_a     = out_a_q;
  assign out_b     = out_b_q;
  assign pass_done = done_q;
  assign hit_count = count_q;
endmodule

// File: rtl/collide_serialiser_chk.sv
module collide_serialiser_chk #(
  parameter int LANES = 7,
  parameter int IDX_W = 9,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pass_start,
  input logic [LANES-1:0] hit_valid,
  input logic             hit_stall,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_a,
  input logic [IDX_W-1:0] out_b,
  input logic             pass_done,
  input logic [CNT_W-1:0] hit_count,
  input logic [LANES-1:0] grant
);
  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_b)); // R4
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    hit_stall |-> hit_valid == '0); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !pass_start && out_valid && out_ready |=> hit_count == CNT_W'($past(hit_count) + 1'b1)); // R6
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    pass_start |=> hit_count == '0); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    pass_done |-> !out_valid); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !pass_done && hit_count == '0); // R8
endmodule

bind collide_serialiser collide_serialiser_chk #(
  .LANES(LANES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pass_start (pass_start),
  .hit_valid  (hit_valid),
  .hit_stall  (hit_stall),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_a      (out_a),
  .out_b      (out_b),
  .pass_done  (pass_done),
  .hit_count  (hit_count),
  .grant      (arb_grant)
);

// File: tb/tb_collide_serialiser.sv
module tb_collide_serialiser;
  localparam int L  = 5;
  localparam int IW = 8;
  localparam int D  = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pass_start = 1'b0, pass_end = 1'b0;
  logic [L-1:0]  hit_valid = '0;
  logic [L*IW-1:0] hit_a = '0, hit_b = '0;
  logic          hit_stall, out_valid, pass_done;
  logic          out_ready = 1'b0;
  logic [IW-1:0] out_a, out_b;
  logic [CW-1:0] hit_count;

  int checks = 0, errors = 0, cycles = 0;
  int pushed = 0, stall_seen = 0;

  always #10 clk = ~clk;

  collide_serialiser #(.LANES(L), .IDX_W(IW), .DEPTH(D), .CNT_W(CW)) dut (
    .clk, .rst, .pass_start, .pass_end, .hit_valid, .hit_a, .hit_b, .hit_stall,
    .out_valid, .out_ready, .out_a, .out_b, .pass_done, .hit_count
  );

  // Behavioural reference model
  logic [2*IW-1:0] q [L][$];
  bit  m_ov, m_hold, m_end, m_done, m_stall;
  logic [IW-1:0] m_a, m_b;
  int  m_ptr, m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < L; k++) q[k].delete();
      m_ov = 0; m_hold = 0; m_end = 0; m_done = 0; m_stall = 0;
      m_ptr = 0; m_cnt = 0; m_a = '0; m_b = '0;
    end else begin
      bit hs, all_empty, dn, found;
      hs = m_ov && out_ready;
      all_empty = 1;
      for (int k = 0; k < L; k++) if (q[k].size() != 0) all_empty = 0;
      dn = m_end && all_empty && !m_ov;
      m_hold = m_ov && !out_ready;
      if (!m_ov || out_ready) begin
        found = 0;
        for (int k = 0; k < L; k++) begin
          int idx;
          idx = (m_ptr + k) % L;
          if (!found && q[idx].size() != 0) begin
            logic [2*IW-1:0] w;
            found = 1;
            w = q[idx].pop_front();
            m_a = w[2*IW-1:IW];
            m_b = w[IW-1:0];
            m_ptr = (idx + 1) % L;
          end
        end
        m_ov = found;
      end
      for (int k = 0; k < L; k++)
        if (hit_valid[k]) q[k].push_back({hit_a[k*IW +: IW], hit_b[k*IW +: IW]});
      m_stall = 0;
      for (int k = 0; k < L; k++) if (q[k].size() >= D-1) m_stall = 1;
      if (pass_start) begin
        m_cnt = 0; m_end = 0; m_done = 0;
      end else begin
        if (hs) m_cnt = (m_cnt + 1) % (1 << CW);
        if (pass_end) m_end = 1;
        m_done = dn;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (hit_stall) stall_seen++;
      check(out_valid == m_ov, "R3 out_valid", int'(out_valid), int'(m_ov));
      if (m_ov) begin
        check(out_a == m_a, m_hold ? "R4 out_a hold" : "R2 out_a order", int'(out_a), int'(m_a));
        check(out_b == m_b, "R1 out_b pairing", int'(out_b), int'(m_b));
      end
      check(hit_stall == m_stall, "R5 stall", int'(hit_stall), int'(m_stall));
      check(int'(hit_count) == m_cnt, "R6 count", int'(hit_count), m_cnt);
      check(pass_done == m_done, "R7 done", int'(pass_done), int'(m_done));
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive(input int density, input int rdy_pct, input logic [L-1:0] lane_mask);
    hit_valid = '0;
    if (!hit_stall) begin
      for (int k = 0; k < L; k++) begin
        if (lane_mask[k] && ($urandom % 100) < density) begin
          hit_valid[k] = 1'b1;
          hit_a[k*IW +: IW] = IW'($urandom);
          hit_b[k*IW +: IW] = IW'($urandom);
          pushed++;
        end
      end
    end
    out_ready = (($urandom % 100) < rdy_pct);
  endtask

  task automatic run_phase(input int n, input int density, input int rdy_pct,
                           input logic [L-1:0] lane_mask);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(density, rdy_pct, lane_mask);
    end
    @(negedge clk);
    hit_valid = '0;
  endtask

  task automatic finish_pass(input string tag);
    int wait_n;
    @(negedge clk);
    pass_end = 1'b1;
    @(negedge clk);
    pass_end = 1'b0;
    wait_n = 0;
    while (!pass_done && wait_n < 300) begin
      out_ready = (($urandom % 100) < 60);
      @(negedge clk);
      wait_n++;
    end
    check(pass_done == 1'b1, tag, int'(pass_done), 1);
    check(int'(hit_count) == pushed, "R5 no pair lost", int'(hit_count), pushed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    check(hit_stall == 1'b0, "R8 stall", int'(hit_stall), 0);
    check(pass_done == 1'b0, "R8 done", int'(pass_done), 0);
    check(hit_count == '0, "R8 count", int'(hit_count), 0);
    rst = 1'b0;
    @(negedge clk);
    pass_start = 1'b1;
    @(negedge clk);
    pass_start = 1'b0;

    run_phase(60, 50, 100, '1);              // R1 R2 steady flow
    run_phase(80, 90, 30, '1);               // R4 R5 back-pressure
    run_phase(60, 70, 70, L'(1 | (1 << (L-1)))); // R3 skip and wrap
    run_phase(40, 60, 50, L'(1 << 2));       // R3 single lane
    finish_pass("R7 done after first pass");
    check(stall_seen > 0, "R5 stall reached", stall_seen, 1);

    // Second pass: R6 clear, end marker on the same edge as last reports
    @(negedge clk);
    pass_start = 1'b1;
    @(negedge clk);
    pass_start = 1'b0;
    check(hit_count == '0, "R6 cleared by pass_start", int'(hit_count), 0);
    check(pass_done == 1'b0, "R7 cleared by pass_start", int'(pass_done), 0);
    pushed = 0;
    run_phase(30, 80, 40, '1);
    @(negedge clk);
    drive(100, 0, '1);
    pass_end = 1'b1;
    @(negedge clk);
    hit_valid = '0;
    pass_end = 1'b0;
    finish_pass("R7 done after second pass");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule